// File: doc/BRIEF.md
# Handshake-Paced Byte Transfer Engine

This block moves bytes between a host processor and an embedded controller through a single 8-bit shift register. It uses no shift clock. Three active-low handshake lines set the pace. The host drives the in-progress line and the acknowledge line. The block drives the request line back to the host. A direction input selects the mode. In host-send mode, each handshake step copies the shift register into an outbound buffer. In device-send mode, each step presents the next byte of a response packet in the shift register.

The host writes the two host-driven lines together through a single port write strobe (`pb_wr`). Each write is compared with the previous written pair. A change of the pair while the in-progress line is low advances one byte. When the in-progress line goes high after being low, the transfer closes. At that point the block raises the shift-register interrupt. If any outbound bytes were collected, it also reports the finished host packet with its byte count. Between transfers the request line mirrors every acknowledge toggle, which lets the host resynchronise. Software above the block fills the response buffer and starts a response packet. It also reads the collected host bytes back through a read port.

Top module: `hte_xfer_engine`

## Requirements
- R1: After a synchronous reset the outputs are in their idle state: `treq_n` is 1, and `sr_q`, `sr_irq`, `pkt_done` and `pkt_len` are all 0. The last written handshake pair is taken as both lines high.
- R2: In host-send mode (`dir_host_send`=1), a port write with `pb_tip_n`=0 whose {`pb_tack_n`,`pb_tip_n`} pair differs from the previously written pair stores the current `sr_q` at the next outbound index. If the buffer already holds OUT_DEPTH bytes, nothing is stored.
- R3: `sr_irq` is a one-cycle pulse in the cycle after any of these events: an active-transfer pair change in host-send mode, a byte load in device-send mode, or the end of a transfer.
- R4: In device-send mode, an active-transfer pair change while inbound bytes are pending loads the byte at the inbound index into `sr_q` and advances the index. When no byte is pending, the change leaves `sr_q` unchanged.
- R5: The load of the last byte of a response packet drives `treq_n` to 1 in the following cycle.
- R6: A port write with `pb_tip_n`=1, after a previous write that also had the in-progress line high, sets `treq_n` to the written `pb_tack_n` when the acknowledge value changed.
- R7: A port write with `pb_tip_n`=1 after a write with the in-progress line low ends the transfer. If the outbound count is non-zero, `pkt_done` pulses for one cycle with `pkt_len` equal to the count, and the count returns to 0. `pkt_len` is 0 in every other cycle.
- R8: If response bytes are still pending when a transfer ends, `treq_n` is driven to 0.
- R9: `rsp_start` resets the inbound index to 0 and stores `rsp_len` (at most IN_DEPTH). When `rsp_len` is non-zero, it drives `treq_n` to 0 in the next cycle, and it takes priority over a handshake write in the same cycle.
- R10: A port write with `pb_tip_n`=0 whose pair equals the previous pair has no effect: no byte is stored or loaded, and no interrupt is raised.
- R11: `sr_wr` loads `sr_wdata` into `sr_q` in the next cycle, unless a device-send byte load happens in the same cycle, in which case the inbound byte wins.
- R12: `ob_rdata` returns the outbound buffer entry at `ob_raddr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_host_send | input | 1 | 1: host sends into the outbound buffer; 0: device sends the response |
| pb_wr | input | 1 | Strobe: host writes the handshake pair |
| pb_tip_n | input | 1 | Transfer-in-progress, active low |
| pb_tack_n | input | 1 | Transfer-acknowledge, active low |
| sr_wr | input | 1 | Host write strobe for the shift register |
| sr_wdata | input | DATA_W | Shift register write data |
| rsp_wr | input | 1 | Response buffer write strobe |
| rsp_waddr | input | IN_AW | Response buffer write address |
| rsp_wdata | input | DATA_W | Response buffer write data |
| rsp_start | input | 1 | Start presenting a response packet |
| rsp_len | input | IN_CW | Response packet length in bytes |
| ob_raddr | input | OUT_AW | Outbound buffer read address |
| treq_n | output | 1 | Transfer request to the host, active low |
| sr_q | output | DATA_W | Shift register contents |
| sr_irq | output | 1 | Shift-register interrupt pulse |
| pkt_done | output | 1 | Host packet completed pulse |
| pkt_len | output | OUT_CW | Byte count of the completed packet |
| ob_rdata | output | DATA_W | Outbound buffer read data |

## Verification
The bench targets several corner cases. One is a repeated write of an unchanged handshake pair: a design that compared against the live lines instead of the last written pair would store or load a duplicate byte. Another is host traffic beyond the outbound depth: a missing bound would wrap the index and report a short or zero length. A third is a transfer that ends with response bytes still pending, where a design that forgot to re-assert the request would leave the host waiting forever. The last is a shift-register write that coincides with a device-send load, where the wrong priority would present the host's own byte as a response byte. A long random phase mixes directions, idle synchronisation toggles and packet restarts against a behavioural model, compared every cycle.

// File: rtl/hte_pkg.sv
package hte_pkg;

  // Classification of one handshake write
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,  // no write, or idle write with no acknowledge change
    EV_ACTIVE = 2'd1,  // write while transfer in progress
    EV_SYNC   = 2'd2,  // idle write with an acknowledge toggle
    EV_END    = 2'd3   // in-progress line released
  } hs_ev_t;

  typedef struct packed {
    logic tack_n;
    logic tip_n;
  } hs_pair_t;

endpackage

// File: rtl/hte_hs_decode.sv
module hte_hs_decode
  import hte_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   pb_wr,
  input  logic   tip_n,
  input  logic   tack_n,
  output hs_ev_t ev,
  output logic   pair_chg
);

  hs_pair_t last_q;
  hs_pair_t cur;

  assign cur.tack_n = tack_n;
  assign cur.tip_n  = tip_n;
  assign pair_chg   = (cur != last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '{tack_n: 1'b1, tip_n: 1'b1};
    end else if (pb_wr) begin
      last_q <= cur;
    end
  end

  always_comb begin
    ev = EV_NONE;
    if (pb_wr) begin
      if (!tip_n)
        ev = EV_ACTIVE;
      else if (!last_q.tip_n)
        ev = EV_END;
      else if (tack_n != last_q.tack_n)
        ev = EV_SYNC;
    end
  end

endmodule

// File: rtl/hte_out_buf.sv
module hte_out_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual port, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/hte_in_buf.sv
module hte_in_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // synchronous write, asynchronous read: distributed RAM
  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/hte_xfer_engine.sv
module hte_xfer_engine
  import hte_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OUT_DEPTH = 16,
  parameter int IN_DEPTH  = 16,
  localparam int OUT_AW   = $clog2(OUT_DEPTH),
  localparam int OUT_CW   = $clog2(OUT_DEPTH + 1),
  localparam int IN_AW    = $clog2(IN_DEPTH),
  localparam int IN_CW    = $clog2(IN_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_host_send,
  input  logic              pb_wr,
  input  logic              pb_tip_n,
  input  logic              pb_tack_n,
  input  logic              sr_wr,
  input  logic [DATA_W-1:0] sr_wdata,
  input  logic              rsp_wr,
  input  logic [IN_AW-1:0]  rsp_waddr,
  input  logic [DATA_W-1:0] rsp_wdata,
  input  logic              rsp_start,
  input  logic [IN_CW-1:0]  rsp_len,
  input  logic [OUT_AW-1:0] ob_raddr,
  output logic              treq_n,
  output logic [DATA_W-1:0] sr_q,
  output logic              sr_irq,
  output logic              pkt_done,
  output logic [OUT_CW-1:0] pkt_len,
  output logic [DATA_W-1:0] ob_rdata
);

  hs_ev_t            ev;
  logic              pair_chg;
  logic [OUT_CW-1:0] out_cnt;
  logic [IN_CW-1:0]  in_idx;
  logic [IN_CW-1:0]  in_len;
  logic [IN_CW-1:0]  in_idx_nx;
  logic [DATA_W-1:0] in_rdata;
  logic              step;
  logic              out_we;
  logic              in_pend;
  logic              in_load;

  hte_hs_decode u_dec (
    .clk      (clk),
    .rst      (rst),
    .pb_wr    (pb_wr),
    .tip_n    (pb_tip_n),
    .tack_n   (pb_tack_n),
    .ev       (ev),
    .pair_chg (pair_chg)
  );

  assign step      = (ev == EV_ACTIVE) && pair_chg;
  assign out_we    = step && dir_host_send && (out_cnt < OUT_CW'(OUT_DEPTH));
  assign in_pend   = (in_idx < in_len);
  assign in_load   = step && !dir_host_send && in_pend;
  assign in_idx_nx = in_idx + IN_CW'(1);

  hte_out_buf #(.DATA_W(DATA_W), .DEPTH(OUT_DEPTH)) u_obuf (
    .clk   (clk),
    .we    (out_we),
    .waddr (out_cnt[OUT_AW-1:0]),
    .wdata (sr_q),
    .raddr (ob_raddr),
    .rdata (ob_rdata)
  );

  hte_in_buf #(.DATA_W(DATA_W), .DEPTH(IN_DEPTH)) u_ibuf (
    .clk   (clk),
    .we    (rsp_wr),
    .waddr (rsp_waddr),
    .wdata (rsp_wdata),
    .raddr (in_idx[IN_AW-1:0]),
    .rdata (in_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      treq_n   <= 1'b1;
      sr_q     <= '0;
      sr_irq   <= 1'b0;
      pkt_done <= 1'b0;
      pkt_len  <= '0;
      out_cnt  <= '0;
      in_idx   <= '0;
      in_len   <= '0;
    end else begin
      sr_irq   <= 1'b0;
      pkt_done <= 1'b0;
      pkt_len  <= '0;
      if (sr_wr)
        sr_q <= sr_wdata;
      unique case (ev)
        EV_ACTIVE: begin
          if (step && dir_host_send) begin
            sr_irq <= 1'b1;
            if (out_we)
              out_cnt <= out_cnt + OUT_CW'(1);
          end
          if (in_load) begin
            sr_q   <= in_rdata;
            in_idx <= in_idx_nx;
            sr_irq <= 1'b1;
            if (in_idx_nx >= in_len)
              treq_n <= 1'b1;
          end
        end
        EV_SYNC: treq_n <= pb_tack_n;
        EV_END: begin
          sr_irq <= 1'b1;
          if (out_cnt != '0) begin
            pkt_done <= 1'b1;
            pkt_len  <= out_cnt;
            out_cnt  <= '0;
          end
          if (in_pend)
            treq_n <= 1'b0;
        end
        default: ;
      endcase
      if (rsp_start) begin
        in_idx <= '0;
        in_len <= rsp_len;
        if (rsp_len != '0)
          treq_n <= 1'b0;
      end
    end
  end

  // R1: idle state right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (treq_n && !sr_irq && !pkt_done && pkt_len == '0));

  // R2: outbound count never exceeds the buffer depth
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    out_cnt <= OUT_CW'(OUT_DEPTH));

  // R5: last response byte releases the request line
  a_r5_last_release: assert property (@(posedge clk) disable iff (rst)
    (in_load && in_idx_nx == in_len && !rsp_start) |=> treq_n);

  // R7: a completed packet never reports zero bytes
  a_r7_len_nonzero: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> (pkt_len != '0));

  // R9: starting a non-empty response requests the host
  a_r9_start_req: assert property (@(posedge clk) disable iff (rst)
    (rsp_start && rsp_len != '0) |=> !treq_n);

  // R10: a repeated pair during a transfer has no effect
  a_r10_repeat_quiet: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_ACTIVE && !pair_chg) |=> (!sr_irq && !pkt_done));

endmodule

// File: tb/hte_xfer_engine_test.sv
`timescale 1ns/1ps
module hte_xfer_engine_test;

  localparam int DW = 8;
  localparam int OD = 16;
  localparam int ID = 16;
  localparam int OAW = $clog2(OD);
  localparam int OCW = $clog2(OD + 1);
  localparam int IAW = $clog2(ID);
  localparam int ICW = $clog2(ID + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_host_send = 1'b0;
  logic pb_wr = 1'b0, pb_tip_n = 1'b1, pb_tack_n = 1'b1;
  logic sr_wr = 1'b0;
  logic [DW-1:0] sr_wdata = '0;
  logic rsp_wr = 1'b0;
  logic [IAW-1:0] rsp_waddr = '0;
  logic [DW-1:0] rsp_wdata = '0;
  logic rsp_start = 1'b0;
  logic [ICW-1:0] rsp_len = '0;
  logic [OAW-1:0] ob_raddr = '0;
  logic treq_n, sr_irq, pkt_done;
  logic [DW-1:0] sr_q, ob_rdata;
  logic [OCW-1:0] pkt_len;

  always #2 clk = ~clk;

  hte_xfer_engine #(.DATA_W(DW), .OUT_DEPTH(OD), .IN_DEPTH(ID)) uut (
    .clk(clk), .rst(rst), .dir_host_send(dir_host_send),
    .pb_wr(pb_wr), .pb_tip_n(pb_tip_n), .pb_tack_n(pb_tack_n),
    .sr_wr(sr_wr), .sr_wdata(sr_wdata),
    .rsp_wr(rsp_wr), .rsp_waddr(rsp_waddr), .rsp_wdata(rsp_wdata),
    .rsp_start(rsp_start), .rsp_len(rsp_len), .ob_raddr(ob_raddr),
    .treq_n(treq_n), .sr_q(sr_q), .sr_irq(sr_irq),
    .pkt_done(pkt_done), .pkt_len(pkt_len), .ob_rdata(ob_rdata)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit started = 0;
  bit done = 0;

  // behavioural reference model
  int m_treq, m_sr, m_irq, m_done, m_len, m_obr;
  int last_tack, last_tip, ocnt, iidx, ilen;
  int ob_mem [OD];
  int in_mem [ID];

  initial begin
    for (int i = 0; i < OD; i++) ob_mem[i] = 0;
    for (int i = 0; i < ID; i++) in_mem[i] = 0;
  end

  always @(posedge clk) begin
    int sr_old;
    cycles++;
    started = 1;
    if (rst) begin
      m_treq = 1; m_sr = 0; m_irq = 0; m_done = 0; m_len = 0;
      last_tack = 1; last_tip = 1; ocnt = 0; iidx = 0; ilen = 0;
      m_obr = ob_mem[ob_raddr];
    end else begin
      m_obr = ob_mem[ob_raddr];
      sr_old = m_sr;
      m_irq = 0; m_done = 0; m_len = 0;
      if (sr_wr) m_sr = sr_wdata;
      if (pb_wr) begin
        if (pb_tip_n == 0) begin
          if (pb_tack_n != last_tack || pb_tip_n != last_tip) begin
            if (dir_host_send) begin
              m_irq = 1;
              if (ocnt < OD) begin ob_mem[ocnt] = sr_old; ocnt++; end
            end else if (iidx < ilen) begin
              m_sr = in_mem[iidx]; iidx++; m_irq = 1;
              if (iidx >= ilen) m_treq = 1;
            end
          end
        end else if (last_tip == 0) begin
          m_irq = 1;
          if (ocnt > 0) begin m_done = 1; m_len = ocnt; ocnt = 0; end
          if (iidx < ilen) m_treq = 0;
        end else if (pb_tack_n != last_tack) begin
          m_treq = pb_tack_n;
        end
        last_tack = pb_tack_n; last_tip = pb_tip_n;
      end
      if (rsp_start) begin
        iidx = 0; ilen = rsp_len;
        if (rsp_len != 0) m_treq = 0;
      end
      if (rsp_wr) in_mem[rsp_waddr] = rsp_wdata;
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      cmp("R5/R6/R8/R9 treq_n", treq_n, m_treq);
      cmp("R4/R11 sr_q", sr_q, m_sr);
      cmp("R3 sr_irq", sr_irq, m_irq);
      cmp("R7 pkt_done", pkt_done, m_done);
      cmp("R7 pkt_len", pkt_len, m_len);
      cmp("R12 ob_rdata", ob_rdata, m_obr);
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic hs(input logic tip, input logic tack);
    pb_wr = 1; pb_tip_n = tip; pb_tack_n = tack;
    tick();
    pb_wr = 0;
  endtask

  task automatic wsr(input logic [DW-1:0] v);
    sr_wr = 1; sr_wdata = v;
    tick();
    sr_wr = 0;
  endtask

  task automatic wrsp(input int a, input logic [DW-1:0] v);
    rsp_wr = 1; rsp_waddr = IAW'(a); rsp_wdata = v;
    tick();
    rsp_wr = 0;
  endtask

  task automatic start(input int n);
    rsp_start = 1; rsp_len = ICW'(n);
    tick();
    rsp_start = 0;
  endtask

  task automatic readob(input int a, input int exp, input string tag);
    ob_raddr = OAW'(a);
    tick();
    cmp(tag, ob_rdata, exp);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    // R1: idle outputs after reset
    cmp("R1 treq_n", treq_n, 1);
    cmp("R1 sr_q", sr_q, 0);
    cmp("R1 pkt_len", pkt_len, 0);

    // R2 / R10 / R7: host sends three bytes
    dir_host_send = 1;
    wsr(8'hA1); hs(0, 1);
    cmp("R3 irq on host step", sr_irq, 1);
    wsr(8'hB2); hs(0, 0);
    wsr(8'hC3); hs(0, 1);
    hs(0, 1);
    cmp("R10 repeated pair no irq", sr_irq, 0);
    hs(1, 1);
    cmp("R7 pkt_done", pkt_done, 1);
    cmp("R7 pkt_len three", pkt_len, 3);
    readob(0, 8'hA1, "R12 ob byte0");
    readob(1, 8'hB2, "R2 ob byte1");
    readob(2, 8'hC3, "R2 ob byte2");

    // R2: overflow is bounded by the depth
    for (int i = 0; i < OD + 3; i++) begin
      wsr(DW'(i + 16)); hs(0, 1'(i));
    end
    hs(1, 1);
    cmp("R2 pkt_len capped", pkt_len, OD);

    // R9 / R4 / R5: device response of three bytes
    dir_host_send = 0;
    wrsp(0, 8'h11); wrsp(1, 8'h22); wrsp(2, 8'h33);
    start(3);
    cmp("R9 treq asserted", treq_n, 0);
    hs(0, 1); cmp("R4 byte0", sr_q, 8'h11);
    hs(0, 0); cmp("R4 byte1", sr_q, 8'h22);
    hs(0, 1); cmp("R4 byte2", sr_q, 8'h33);
    cmp("R5 treq released", treq_n, 1);
    hs(0, 0);
    cmp("R4 nothing pending", sr_q, 8'h33);
    hs(1, 0);
    cmp("R7 no packet on empty end", pkt_done, 0);

    // R6: idle synchronisation follows acknowledge
    hs(1, 1); cmp("R6 treq follows high", treq_n, 1);
    hs(1, 0); cmp("R6 treq follows low", treq_n, 0);
    hs(1, 1); cmp("R6 treq follows high again", treq_n, 1);

    // R8 / R11: pending bytes at end, sr write collision
    wrsp(0, 8'h44); wrsp(1, 8'h55); wrsp(2, 8'h66); wrsp(3, 8'h77);
    start(4);
    hs(0, 1);
    hs(1, 1);
    hs(1, 0); hs(1, 1);
    cmp("R6 sync toggled treq high", treq_n, 1);
    sr_wr = 1; sr_wdata = 8'hEE;
    hs(0, 1);
    sr_wr = 0;
    cmp("R11 load wins over sr write", sr_q, 8'h55);
    hs(1, 1);
    cmp("R8 treq re-asserted", treq_n, 0);
    wsr(8'h5A);
    cmp("R11 plain sr write", sr_q, 8'h5A);

    // random phase against the model
    for (int c = 0; c < 3000; c++) begin
      if (($urandom % 64) == 0) dir_host_send = ~dir_host_send;
      pb_wr = ($urandom % 3) == 0;
      pb_tip_n = ($urandom % 4) == 0;
      pb_tack_n = 1'($urandom);
      sr_wr = ($urandom % 4) == 0;
      sr_wdata = DW'($urandom);
      rsp_wr = ($urandom % 4) == 0;
      rsp_waddr = IAW'($urandom);
      rsp_wdata = DW'($urandom);
      rsp_start = ($urandom % 40) == 0;
      rsp_len = ICW'($urandom % (ID + 1));
      ob_raddr = OAW'($urandom);
      tick();
    end
    pb_wr = 0; sr_wr = 0; rsp_wr = 0; rsp_start = 0;
    tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule